// File: doc/BRIEF.md
# Critical-First Line Fill Buffer

This block sits beside a unified cache and services read misses. When the cache misses on a read that has a valid translation and may be cached, the block issues one burst request for the whole line. The burst starts at the missed doubleword and wraps around the line. The block collects the returning beats in a small buffer. The first beat is handed to the CPU in the cycle it arrives. When the last beat lands, the complete line is written into the cache.

The CPU keeps working while the fill is in flight. A pending request for another line that hits in the cache is answered from the cache. A request for a doubleword of the line being filled has three outcomes:
- It is answered from the buffer if that beat has already arrived.
- It is answered straight from the bus as the beat arrives, when streaming is enabled.
- Otherwise it waits.

A miss to any other line waits until the running fill is finished.

Top module: `critical_fill_buf`

## Requirements
- R1: In the idle state, a request with `lkp_hit` low, `xlat_ok` high and `inhibit` low raises `bus_req_vld` for one cycle, with `bus_req_line`/`bus_req_dw` equal to the request. It does not answer in that cycle.
- R2: In the idle state, a missing request that has `inhibit` high or `xlat_ok` low raises `byp_vld`. It raises neither `bus_req_vld` nor `rsp_vld`.
- R3: Beat k (k = 0..3) of a fill carries doubleword (critical + k) mod 4 and is stored in that slot. For example, critical 2 gives the order 2, 3, 0, 1.
- R4: The first beat of a fill is returned on `rsp_data` with `rsp_vld` high in the same cycle it arrives on `beat_data`.
- R5: A later beat is returned in its arrival cycle only when `stream_en` is high and a request for that doubleword of the filling line is pending. With `stream_en` low, that request is not answered in the arrival cycle.
- R6: During a fill, a request for a doubleword of the filling line that has already arrived is answered in the same cycle from the buffer.
- R7: During a fill, a request for a doubleword of the filling line that has not arrived gets no answer, and stays unanswered until that beat arrives.
- R8: A request that hits (`lkp_hit` high) for any line other than the filling one is answered in the same cycle with `lkp_data`, whether or not a fill is running.
- R9: During a fill, a miss to another line gets no answer and no new `bus_req_vld`. The next fill starts in the first idle cycle after the current one finishes.
- R10: In the cycle of the fourth beat, `wr_en`, `fill_done` and `wr_valid` are high, `wr_dirty` is low and `wr_line` is the filling line. `wr_data` holds doubleword i in bits [64i+63:64i]. None of these strobes is high in any other cycle.
- R11: During reset all outputs that report events (`rsp_vld`, `byp_vld`, `bus_req_vld`, `wr_en`, `fill_done`) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_en | input | 1 | Allow forwarding of non-critical beats on arrival |
| req_vld | input | 1 | CPU read request pending (held until answered or bypassed) |
| req_line | input | 20 | Line address of the request |
| req_dw | input | 2 | Doubleword index within the line |
| xlat_ok | input | 1 | Address translation hit |
| inhibit | input | 1 | Cache-inhibited attribute |
| lkp_hit | input | 1 | Cache tag lookup hit for the request |
| lkp_data | input | 64 | Cache data for the request |
| rsp_vld | output | 1 | Read data returned this cycle |
| rsp_data | output | 64 | Returned doubleword |
| byp_vld | output | 1 | Request handed to the uncached path |
| bus_req_vld | output | 1 | Start a line burst |
| bus_req_line | output | 20 | Burst line address |
| bus_req_dw | output | 2 | Critical doubleword of the burst |
| beat_vld | input | 1 | Burst beat arriving |
| beat_data | input | 64 | Burst beat data |
| wr_en | output | 1 | Write completed line into the cache |
| wr_line | output | 20 | Line address to install |
| wr_data | output | 256 | Complete line, doubleword 0 in the low bits |
| wr_valid | output | 1 | Valid bit value written with the line |
| wr_dirty | output | 1 | Dirty bit value written with the line |
| fill_done | output | 1 | Fill finished this cycle |

## Verification
The hardest situation to reach is a request for the filling line that meets its beat in the very cycle it arrives. Whether it is answered then depends on three things: whether the beat is the first of the burst, the setting of `stream_en`, and whether the beat is the last one, after which the buffer is gone and the cache must answer. The stimulus runs a bus process and a CPU process side by side. Beat gaps are chosen so that requests land before, on and after arrival. One fill uses critical index 3 with back-to-back beats to force the wrap, and one uses streaming off so that the last requested beat has to come from the cache once the line is installed.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
   typedef enum logic {
      FB_IDLE = 1'b0,
      FB_FILL = 1'b1
   } fb_state_e;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_CACHE = 2'd1,
      SRC_BUF   = 2'd2,
      SRC_BUS   = 2'd3
   } rsp_src_e;
endpackage

// File: rtl/cfb_seq.sv
module cfb_seq
   import cfb_pkg::*;
#(
   parameter int BEATS   = 4,
   parameter int LINE_AW = 20,
   localparam int IDX_W  = $clog2(BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LINE_AW-1:0] start_line,
   input  logic [IDX_W-1:0]   start_dw,
   input  logic               beat_vld,
   output logic               busy,
   output logic [LINE_AW-1:0] fill_line,
   output logic [IDX_W-1:0]   beat_idx,
   output logic               first_beat,
   output logic               last_beat
);
   fb_state_e          state_q;
   logic [LINE_AW-1:0] line_q;
   logic [IDX_W-1:0]   crit_q;
   logic [IDX_W-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FB_IDLE;
         line_q  <= '0;
         crit_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            FB_IDLE: if (start) begin
               state_q <= FB_FILL;
               line_q  <= start_line;
               crit_q  <= start_dw;
               cnt_q   <= '0;
            end
            default: if (beat_vld) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == IDX_W'(BEATS-1)) state_q <= FB_IDLE;
            end
         endcase
      end
   end

   // wrap happens by modular IDX_W arithmetic (BEATS is a power of two)
   assign busy       = (state_q == FB_FILL);
   assign fill_line  = line_q;
   assign beat_idx   = crit_q + cnt_q;
   assign first_beat = busy && (cnt_q == '0);
   assign last_beat  = busy && beat_vld && (cnt_q == IDX_W'(BEATS-1));

   p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_cnt_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cnt_q == '0) && (beat_idx == crit_q));
   p_done_leaves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |=> !busy);
endmodule

// File: rtl/cfb_store.sv
module cfb_store #(
   parameter int BEATS   = 4,
   parameter int DW_W    = 64,
   localparam int IDX_W  = $clog2(BEATS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    we,
   input  logic [IDX_W-1:0]        widx,
   input  logic [DW_W-1:0]         wdata,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic                    rd_hit,
   output logic [DW_W-1:0]         rd_data,
   output logic [BEATS*DW_W-1:0]   line_data,
   output logic [BEATS-1:0]        vld
);
   logic [BEATS-1:0] vld_q;
   logic [DW_W-1:0]  data_q [BEATS];

   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      logic hit_w;
      assign hit_w = we && (widx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)      vld_q[g] <= 1'b0;
         else if (clear)  vld_q[g] <= 1'b0;
         else if (hit_w)  vld_q[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit_w) data_q[g] <= wdata;
      end

      // merge the arriving beat so the complete line is ready in its cycle
      assign line_data[g*DW_W +: DW_W] = hit_w ? wdata : data_q[g];
   end

   assign rd_hit  = vld_q[rd_idx];
   assign rd_data = data_q[rd_idx];
   assign vld     = vld_q;

   p_slot_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !vld_q[widx]);
   p_clear_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (vld_q == '0));
endmodule

// File: rtl/cfb_fwd.sv
module cfb_fwd
   import cfb_pkg::*;
#(
   parameter int BEATS   = 4,
   parameter int DW_W    = 64,
   parameter int LINE_AW = 20,
   localparam int IDX_W  = $clog2(BEATS)
) (
   input  logic               busy,
   input  logic               req_vld,
   input  logic [LINE_AW-1:0] req_line,
   input  logic [IDX_W-1:0]   req_dw,
   input  logic               lkp_hit,
   input  logic [DW_W-1:0]    lkp_data,
   input  logic               xlat_ok,
   input  logic               inhibit,
   input  logic               stream_en,
   input  logic [LINE_AW-1:0] fill_line,
   input  logic               buf_hit,
   input  logic [DW_W-1:0]    buf_data,
   input  logic               beat_vld,
   input  logic [IDX_W-1:0]   beat_idx,
   input  logic               first_beat,
   input  logic [DW_W-1:0]    beat_data,
   output logic               start,
   output logic               byp,
   output logic               rsp_vld,
   output logic [DW_W-1:0]    rsp_data,
   output rsp_src_e           rsp_src
);
   logic same_line;
   logic beat_match;

   assign same_line  = (req_line == fill_line);
   assign beat_match = beat_vld && (beat_idx == req_dw) && (first_beat || stream_en);

   always_comb begin
      start   = 1'b0;
      byp     = 1'b0;
      rsp_src = SRC_NONE;
      if (req_vld) begin
         if (!busy) begin
            if (lkp_hit)                  rsp_src = SRC_CACHE;
            else if (xlat_ok && !inhibit) start   = 1'b1;
            else                          byp     = 1'b1;
         end else if (same_line) begin
            if (buf_hit)                  rsp_src = SRC_BUF;
            else if (beat_match)          rsp_src = SRC_BUS;
         end else if (lkp_hit) begin
            rsp_src = SRC_CACHE;
         end
      end
   end

   always_comb begin
      case (rsp_src)
         SRC_CACHE: rsp_data = lkp_data;
         SRC_BUF:   rsp_data = buf_data;
         SRC_BUS:   rsp_data = beat_data;
         default:   rsp_data = '0;
      endcase
   end

   assign rsp_vld = (rsp_src != SRC_NONE);
endmodule

// File: rtl/critical_fill_buf.sv
module critical_fill_buf
   import cfb_pkg::*;
#(
   parameter int BEATS   = 4,
   parameter int DW_W    = 64,
   parameter int LINE_AW = 20,
   localparam int IDX_W  = $clog2(BEATS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stream_en,
   input  logic                  req_vld,
   input  logic [LINE_AW-1:0]    req_line,
   input  logic [IDX_W-1:0]      req_dw,
   input  logic                  xlat_ok,
   input  logic                  inhibit,
   input  logic                  lkp_hit,
   input  logic [DW_W-1:0]       lkp_data,
   output logic                  rsp_vld,
   output logic [DW_W-1:0]       rsp_data,
   output logic                  byp_vld,
   output logic                  bus_req_vld,
   output logic [LINE_AW-1:0]    bus_req_line,
   output logic [IDX_W-1:0]      bus_req_dw,
   input  logic                  beat_vld,
   input  logic [DW_W-1:0]       beat_data,
   output logic                  wr_en,
   output logic [LINE_AW-1:0]    wr_line,
   output logic [BEATS*DW_W-1:0] wr_data,
   output logic                  wr_valid,
   output logic                  wr_dirty,
   output logic                  fill_done
);
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two, at least 2");
   end
   if (DW_W < 1 || LINE_AW < 1) begin : g_bad_width
      $error("DW_W and LINE_AW must be positive");
   end

   logic               busy;
   logic [LINE_AW-1:0] fill_line;
   logic [IDX_W-1:0]   beat_idx;
   logic               first_beat;
   logic               last_beat;
   logic               start;
   logic               buf_hit;
   logic [DW_W-1:0]    buf_data;
   logic [BEATS-1:0]   buf_vld;
   rsp_src_e           rsp_src;

   cfb_seq #(.BEATS(BEATS), .LINE_AW(LINE_AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_line(req_line),
      .start_dw(req_dw), .beat_vld(beat_vld), .busy(busy),
      .fill_line(fill_line), .beat_idx(beat_idx),
      .first_beat(first_beat), .last_beat(last_beat));

   cfb_store #(.BEATS(BEATS), .DW_W(DW_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(start), .we(busy && beat_vld),
      .widx(beat_idx), .wdata(beat_data), .rd_idx(req_dw),
      .rd_hit(buf_hit), .rd_data(buf_data), .line_data(wr_data),
      .vld(buf_vld));

   cfb_fwd #(.BEATS(BEATS), .DW_W(DW_W), .LINE_AW(LINE_AW)) u_fwd (
      .busy(busy), .req_vld(req_vld), .req_line(req_line), .req_dw(req_dw),
      .lkp_hit(lkp_hit), .lkp_data(lkp_data), .xlat_ok(xlat_ok),
      .inhibit(inhibit), .stream_en(stream_en), .fill_line(fill_line),
      .buf_hit(buf_hit), .buf_data(buf_data), .beat_vld(beat_vld),
      .beat_idx(beat_idx), .first_beat(first_beat), .beat_data(beat_data),
      .start(start), .byp(byp_vld), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
      .rsp_src(rsp_src));

   assign bus_req_vld  = start;
   assign bus_req_line = req_line;
   assign bus_req_dw   = req_dw;
   assign wr_en        = last_beat;
   assign fill_done    = last_beat;
   assign wr_valid     = last_beat;
   assign wr_dirty     = 1'b0;
   assign wr_line      = fill_line;

   p_byp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byp_vld |-> !bus_req_vld && !rsp_vld);
   p_one_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_vld |=> !bus_req_vld && busy);
   p_full_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> wr_en && wr_valid && !wr_dirty
                    && ($countones(buf_vld) == BEATS-1));
   p_no_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_src == SRC_BUS) |-> beat_vld && (beat_idx == req_dw)
                               && !buf_vld[req_dw]);
   p_buf_arrived_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_src == SRC_BUF) |-> busy && buf_vld[req_dw]);
endmodule

// File: tb/critical_fill_buf_bench.sv
`timescale 1ns/1ps
module critical_fill_buf_bench;
   localparam int LAW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stream_en = 1'b0;
   logic          req_vld = 1'b0;
   logic [19:0]   req_line = '0;
   logic [1:0]    req_dw = '0;
   logic          xlat_ok = 1'b0;
   logic          inhibit = 1'b0;
   logic          lkp_hit = 1'b0;
   logic [63:0]   lkp_data;
   logic          rsp_vld;
   logic [63:0]   rsp_data;
   logic          byp_vld;
   logic          bus_req_vld;
   logic [19:0]   bus_req_line;
   logic [1:0]    bus_req_dw;
   logic          beat_vld = 1'b0;
   logic [63:0]   beat_data = '0;
   logic          wr_en;
   logic [19:0]   wr_line;
   logic [255:0]  wr_data;
   logic          wr_valid;
   logic          wr_dirty;
   logic          fill_done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // reference state
   bit          m_busy = 0;
   logic [19:0] m_line = '0;
   int          m_crit = 0;
   int          m_cnt = 0;
   bit          m_v [4];
   logic [63:0] m_d [4];
   logic [19:0] inst_line [16];
   int          n_inst = 0;

   always #2.5 clk = ~clk;

   function automatic logic [63:0] dat(input logic [7:0] src, input logic [19:0] ln,
                                       input logic [1:0] dw);
      return {src, 4'h0, ln, 30'h0, dw};
   endfunction

   assign lkp_data = dat(8'hCA, req_line, req_dw);

   critical_fill_buf u_critical_fill_buf (
      .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .req_vld(req_vld),
      .req_line(req_line), .req_dw(req_dw), .xlat_ok(xlat_ok),
      .inhibit(inhibit), .lkp_hit(lkp_hit), .lkp_data(lkp_data),
      .rsp_vld(rsp_vld), .rsp_data(rsp_data), .byp_vld(byp_vld),
      .bus_req_vld(bus_req_vld), .bus_req_line(bus_req_line),
      .bus_req_dw(bus_req_dw), .beat_vld(beat_vld), .beat_data(beat_data),
      .wr_en(wr_en), .wr_line(wr_line), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_dirty(wr_dirty), .fill_done(fill_done));

   task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                      input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic bit installed(input logic [19:0] ln);
      for (int i = 0; i < n_inst; i++) if (inst_line[i] == ln) return 1;
      return 0;
   endfunction

   task automatic model_step();
      bit e_bus = 0, e_byp = 0, e_rsp = 0, e_wr = 0;
      logic [63:0] e_dat = '0;
      logic [255:0] e_line = '0;
      string tag = "R7";
      int idx = (m_crit + m_cnt) % 4;
      if (req_vld) begin
         if (!m_busy) begin
            if (lkp_hit) begin e_rsp = 1; e_dat = lkp_data; tag = "R8"; end
            else if (xlat_ok && !inhibit) begin e_bus = 1; tag = "R1"; end
            else begin e_byp = 1; tag = "R2"; end
         end else if (req_line == m_line) begin
            if (m_v[req_dw]) begin e_rsp = 1; e_dat = m_d[req_dw]; tag = "R6"; end
            else if (beat_vld && idx == int'(req_dw)) begin
               if (m_cnt == 0) begin e_rsp = 1; e_dat = beat_data; tag = "R4"; end
               else if (stream_en) begin e_rsp = 1; e_dat = beat_data; tag = "R5"; end
               else tag = "R5";
            end else tag = "R7";
         end else if (lkp_hit) begin e_rsp = 1; e_dat = lkp_data; tag = "R8"; end
         else tag = "R9";
      end
      if (m_busy && beat_vld && m_cnt == 3) begin
         e_wr = 1;
         for (int i = 0; i < 4; i++)
            e_line[i*64 +: 64] = (i == idx) ? beat_data : m_d[i];
      end
      chk(bus_req_vld == e_bus && (!e_bus || (bus_req_line == req_line && bus_req_dw == req_dw)),
          "R1 R9 bus request", {bus_req_vld, bus_req_line, bus_req_dw}, {e_bus, req_line, req_dw});
      chk(byp_vld == e_byp, "R2 bypass", byp_vld, e_byp);
      chk(rsp_vld == e_rsp && (!e_rsp || rsp_data == e_dat), tag,
          {rsp_vld, rsp_data}, {e_rsp, e_dat});
      chk(wr_en == e_wr && fill_done == e_wr && wr_valid == e_wr && !wr_dirty
          && (!e_wr || (wr_data == e_line && wr_line == m_line)),
          "R3 R10 line install", {wr_en, fill_done, wr_valid, wr_dirty, wr_line, wr_data},
          {e_wr, e_wr, e_wr, 1'b0, m_line, e_line});
      // advance reference to the state after the coming edge
      if (!m_busy) begin
         if (e_bus) begin
            m_busy = 1; m_line = req_line; m_crit = int'(req_dw); m_cnt = 0;
            for (int i = 0; i < 4; i++) m_v[i] = 0;
         end
      end else if (beat_vld) begin
         m_d[idx] = beat_data; m_v[idx] = 1; m_cnt++;
         if (m_cnt == 4) m_busy = 0;
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         #2;
         cycles++;
         if (!rst_n) begin
            chk(!rsp_vld && !byp_vld && !bus_req_vld && !wr_en && !fill_done,
                "R11 reset", {rsp_vld, byp_vld, bus_req_vld, wr_en, fill_done}, 0);
         end else begin
            model_step();
         end
         if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_up();
         end
      end
   end

   // entry and exit at a falling edge
   task automatic cpu_read(input logic [19:0] ln, input logic [1:0] dw,
                           input bit xok, input bit inh);
      req_vld = 1; req_line = ln; req_dw = dw; xlat_ok = xok; inhibit = inh;
      forever begin
         #0.5 lkp_hit = installed(ln);
         #0.5;
         if (rsp_vld || byp_vld) break;
         @(negedge clk);
      end
      @(negedge clk);
      req_vld = 0; lkp_hit = 0;
   endtask

   task automatic bus_fill(input int gap);
      logic [19:0] ln;
      logic [1:0]  cr;
      forever begin
         #1;
         if (bus_req_vld) break;
         @(negedge clk);
      end
      ln = bus_req_line; cr = bus_req_dw;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         beat_vld = 0;
         repeat (gap) @(negedge clk);
         beat_vld = 1;
         beat_data = dat(8'hB5, ln, cr + 2'(k));   // R3 wrap order
      end
      @(negedge clk);
      beat_vld = 0;
      inst_line[n_inst] = ln; n_inst++;
   endtask

   initial begin
      inst_line[0] = 20'h00A11; n_inst = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R8 plain hit, R2 bypasses
      cpu_read(20'h00A11, 2'd1, 1, 0);
      cpu_read(20'h00B22, 2'd0, 1, 1);
      cpu_read(20'h00B22, 2'd3, 0, 0);
      // streaming fill, critical 2: R4 R5 R6 R8 R9
      stream_en = 1;
      fork
         begin
            cpu_read(20'h00C33, 2'd2, 1, 0);
            cpu_read(20'h00C33, 2'd3, 1, 0);
            cpu_read(20'h00C33, 2'd2, 1, 0);
            cpu_read(20'h00A11, 2'd0, 1, 0);
            cpu_read(20'h00D44, 2'd1, 1, 0);
         end
         begin
            bus_fill(3);
            bus_fill(1);
         end
      join
      // streaming off, critical 0: R5 negative, R7, cache after install
      stream_en = 0;
      fork
         begin
            cpu_read(20'h00E55, 2'd0, 1, 0);
            cpu_read(20'h00E55, 2'd1, 1, 0);
            cpu_read(20'h00E55, 2'd3, 1, 0);
         end
         bus_fill(2);
      join
      // back-to-back beats, critical 3 wraps to 0: R3
      stream_en = 1;
      fork
         begin
            cpu_read(20'h00F66, 2'd3, 1, 0);
            cpu_read(20'h00F66, 2'd0, 1, 0);
            cpu_read(20'h00F66, 2'd1, 1, 0);
            cpu_read(20'h00F66, 2'd2, 1, 0);
         end
         bus_fill(0);
      join
      cpu_read(20'h00F66, 2'd2, 1, 0);
      repeat (3) @(negedge clk);
      finish_up();
   end
endmodule